// File: doc/BRIEF.md
# Carry-Toggled Phase-Accumulator Square-Wave Generator

This block makes a square wave of programmable frequency with an exact 50% duty cycle on a single output. A frequency word is presented on a data bus together with a one-cycle write strobe and is captured into a holding register. On every clock the phase accumulator adds the held word to itself. Each time that sum wraps past the top of the accumulator range, the output flip-flop inverts.

Because every inversion is half of an output period, the output frequency is f_clk × word / 2^(ACC_W+1). With the default 32-bit accumulator, one word LSB gives a 1 Hz step when the clock runs at 2^33 Hz. For a slower clock, the word is scaled to match. The adder only ever sees the held copy of the word, so a word that is still changing on the bus never disturbs the waveform. The block uses no waveform memory, no DAC path and no PLL.

Top module: `sqwave_nco`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator, the holding register and the output are cleared, so `wave_out` is 0 in the cycle after that edge.
- R2: When `load_en` is 1 at an edge, `load_word` is captured into the holding register at that edge. The first accumulation that uses the new word happens at the following edge.
- R3: When `load_en` is 0, the holding register keeps its value, and changes on `load_word` have no effect on `wave_out`.
- R4: At each edge the accumulator is replaced by the low ACC_W bits of (accumulator + held word). `wave_out` inverts at exactly those edges where that sum has bit ACC_W set, and keeps its level at every other edge. This includes words large enough to carry on almost every clock.
- R5: A held word of zero produces no carries, so `wave_out` keeps its current level, whether that level is 0 or 1.
- R6: With the word 2^(ACC_W-2) loaded into a cleared accumulator, `wave_out` inverts every 4 clocks, giving 4 cycles high and 4 cycles low.
- R7: Asserting `rst` while the wave is running returns `wave_out` to 0 and restarts the phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write strobe for the frequency word |
| load_word | input | ACC_W (32) | Frequency word to capture |
| wave_out | output | 1 | Registered square-wave output |

## Verification
The bound checker checks the register-level rules on every cycle: reset clearing, capture on the strobe, a stable holding register when the strobe is low, inversion of the output at every carry and only then, and a steady output while the held word is zero. Three behaviours are visible only through the bench's scenarios against its behavioural model: the exact edge where a carry falls, the 4-high/4-low period of R6, and restart of the phase after a reset in mid-run. The bench also uses words near all-ones that carry on almost every clock.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;
  localparam int unsigned SQW_ACC_W = 32;
  typedef logic [SQW_ACC_W-1:0] sqw_word_t;
endpackage

// File: rtl/sqw_word_hold.sv
module sqw_word_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end
endmodule

// File: rtl/sqw_phase_acc.sv
module sqw_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  output logic         wrap
);
  localparam int unsigned SUM_W = W + 1;

  logic [W-1:0]     phase_q;
  logic [SUM_W-1:0] sum;

  // The extra top bit is the carry out of the add, so one wrap gives one carry.
  assign sum  = {1'b0, phase_q} + {1'b0, step};
  assign wrap = sum[W];

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= sum[W-1:0];
  end
endmodule

// File: rtl/sqw_toggle.sv
module sqw_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic level_q
);
  always_ff @(posedge clk) begin
    if (rst)       level_q <= 1'b0;
    else if (flip) level_q <= ~level_q;
  end
endmodule

// File: rtl/sqwave_nco.sv
module sqwave_nco
  import sqwave_pkg::*;
#(
  parameter int unsigned ACC_W = SQW_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [ACC_W-1:0] load_word,
  output logic             wave_out
);
  logic [ACC_W-1:0] hold_q;
  logic             carry;

  sqw_word_hold #(.W(ACC_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(load_en), .wr_data(load_word), .word_q(hold_q)
  );

  sqw_phase_acc #(.W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .step(hold_q), .wrap(carry)
  );

  sqw_toggle u_tgl (
    .clk(clk), .rst(rst), .flip(carry), .level_q(wave_out)
  );
endmodule

// File: rtl/sqwave_nco_chk.sv
module sqwave_nco_chk #(
  parameter int unsigned ACC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [ACC_W-1:0] load_word,
  input logic [ACC_W-1:0] hold_q,
  input logic             carry,
  input logic             wave_out
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !wave_out);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> hold_q == $past(load_word));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(hold_q));

  // R4
  toggle_on_carry_chk: assert property (@(posedge clk) disable iff (rst)
    carry |=> wave_out != $past(wave_out));

  // R4
  no_carry_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !carry |=> $stable(wave_out));

  // R5
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q == '0) |-> !carry);
endmodule

bind sqwave_nco sqwave_nco_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
  .hold_q(hold_q), .carry(carry), .wave_out(wave_out)
);

// File: tb/sqwave_nco_tb.sv
module sqwave_nco_tb;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_en = 1'b0;
  logic [W-1:0] load_word = '0;
  logic         wave_out;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint unsigned m_acc  = 0;
  longint unsigned m_hold = 0;
  bit              m_out  = 1'b0;
  int              flips  = 0;

  sqwave_nco u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word), .wave_out(wave_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    longint unsigned s;
    if (rst) begin
      m_acc = 0; m_hold = 0; m_out = 1'b0;
    end else begin
      s = m_acc + m_hold;
      if (s >= 64'h1_0000_0000) begin
        m_out = ~m_out;
        flips++;
      end
      m_acc = s & 64'hFFFF_FFFF;
      if (load_en) m_hold = longint'(load_word);
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    n_cmp++;
    if (wave_out !== m_out) begin
      n_bad++;
      $display("FAIL %s: wave_out=%0b expected=%0b at %0t", cur_req, wave_out, m_out, $time);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] w);
    @(negedge clk);
    load_en = 1'b1; load_word = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic check_flips(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: flips=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic check_level(input string req, input bit exp);
    n_cmp++;
    if (wave_out !== exp) begin
      n_bad++;
      $display("FAIL %s: wave_out=%0b expected=%0b", req, wave_out, exp);
    end
  endtask

  initial begin
    int f0;
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    idle(10);
    check_level("R1", 1'b0);

    // R6: quarter-range word gives 4 high / 4 low
    cur_req = "R6";
    load(32'h4000_0000);
    f0 = flips;
    idle(64);
    check_flips("R6", flips - f0, 16);

    // R2: change of word, first use at the edge after capture
    cur_req = "R2";
    load(32'h1234_5678);
    idle(100);

    // R3: bus activity without strobe has no effect
    cur_req = "R3";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      load_word = 32'hFFFF_FFFF - 32'(i * 977);
    end
    idle(20);

    // R4: near-all-ones words carry on almost every clock
    cur_req = "R4";
    load(32'hFFFF_FFFF);
    idle(50);
    load(32'hFFFF_FFFE);
    idle(50);
    load(32'h8000_0001);
    idle(50);

    // R5: zero word freezes the level, whatever it is
    cur_req = "R5";
    load(32'h4000_0000);
    while (wave_out !== 1'b1) @(negedge clk);
    load(32'h0);
    f0 = flips;
    idle(30);
    check_flips("R5", flips - f0, 0);
    check_level("R5", 1'b1);

    // R7: reset in mid-run clears output and phase
    cur_req = "R7";
    load(32'h3000_0001);
    idle(17);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_level("R7", 1'b0);
    load(32'h4000_0000);
    f0 = flips;
    idle(32);
    check_flips("R7", flips - f0, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule